// File: doc/BRIEF.md
# Key-Guarded Configuration Register Bank

This block holds a small set of configuration registers behind a software write lock. A 16-bit key is written to a dedicated lock register. The key value 0xAEE8 opens the bank. Any other key value closes it. While the bank is closed, writes to the guarded registers are dropped. Each dropped write is reported by a one-cycle error pulse.

The guarded set contains two kinds of register. The first kind is a number of general 32-bit configuration words. The second is a single power-down control bit for a retention memory, which drives a power-switch enable pin. The power-down bit is one-way: once set, only reset can clear it.

The bus is a simple synchronous write port with a combinational read port. Byte addresses are fully decoded, so an unaligned address maps to nothing. The lock register can be written in every state, so software can always reopen the bank.

Top module: `cfg_keylock`

## Requirements
- R1: After reset the bank is open, every general word reads 0, the power-down register reads 0, `pwr_sw_en` is 0 and `wr_err` is 0.
- R2: A write to the lock register (byte offset 0x038) whose `wdata[15:0]` equals 0xAEE8 leaves the bank open from the next cycle, whatever `wdata[31:16]` holds.
- R3: A write to the lock register whose `wdata[15:0]` differs from 0xAEE8 closes the bank from the next cycle; bits 31:16 take no part in the comparison.
- R4: Reading the lock register returns 1 in bit 0 when closed and 0 when open; bits 31:1 read 0.
- R5: General word i sits at byte offset 4*i (default: 0x000 and 0x004). While open, a write stores all 32 bits, and the stored value reads back.
- R6: While closed, writes to the general words and to the power-down register leave their contents unchanged.
- R7: `wr_err` is 1 in the cycle after a write to a guarded register that was dropped because the bank was closed. In every other cycle after reset it is 0.
- R8: The power-down register sits at byte offset 0x034. While open, writing 1 to bit 0 sets it. Bit 0 reads back the state and drives `pwr_sw_en`; bits 31:1 read 0.
- R9: Once the power-down bit is 1, no write can clear it; only reset returns it to 0.
- R10: The lock register accepts writes while closed, so writing the key then reopens the bank, and no error is raised.
- R11: Any other byte address, including an unaligned one, reads 0, and a write to it changes no register and raises no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 8 | Byte address for both reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pwr_sw_en | output | 1 | Retention-memory power-switch enable (power-down bit) |
| wr_err | output | 1 | One-cycle pulse after a write dropped by the lock |

## Verification
The assertions assume that `wr_en`, `addr` and `wdata` are stable and known around each rising edge. They also assume that a write lasts exactly one cycle, so every dropped write produces its own error pulse. The bench changes inputs only on falling edges and raises `wr_en` for a single cycle per write. Between writes it idles for a cycle to sample `wr_err` and read back the registers. The stimulus covers:
- a strided sweep of 16-bit key values, together with every single-bit neighbour of the key;
- every byte address, written once with the bank open and once with it closed.

// File: rtl/cfg_keylock_pkg.sv
package cfg_keylock_pkg;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int KEY_W   = 16;
    localparam logic [KEY_W-1:0]  OPEN_KEY = 16'hAEE8;
    localparam logic [ADDR_W-1:0] PD_OFS   = 8'h34;
    localparam logic [ADDR_W-1:0] LOCK_OFS = 8'h38;
endpackage

// File: rtl/keylock_state.sv
module keylock_state
    import cfg_keylock_pkg::*;
#(
    parameter int                KW  = KEY_W,
    parameter logic [KW-1:0]     KEY = OPEN_KEY
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_lock,
    input  logic [KW-1:0] key_in,
    output logic          locked
);
    typedef struct packed {
        logic closed;
    } lk_t;

    lk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_lock) begin
            st_d.closed = (key_in != KEY);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked = st_q.closed;

    AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lock && key_in == KEY) |=> !locked); // R2
    AST_OTHER_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lock && key_in != KEY) |=> locked); // R3
endmodule

// File: rtl/guarded_bank.sv
module guarded_bank
    import cfg_keylock_pkg::*;
#(
    parameter int NUM_GEN = 2,
    parameter int AW      = ADDR_W,
    parameter int DW      = DATA_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [AW-1:0]               addr,
    input  logic [DW-1:0]               wdata,
    input  logic                        locked,
    output logic [NUM_GEN-1:0][DW-1:0]  gen_words,
    output logic                        pd_bit,
    output logic                        drop_pulse
);
    localparam int GEN_SPAN = 4 * NUM_GEN;

    typedef struct packed {
        logic [NUM_GEN-1:0][DW-1:0] gen;
        logic                       pd;
        logic                       err;
    } bank_t;

    bank_t st_d, st_q;
    logic [NUM_GEN-1:0] gen_hit;
    logic               pd_hit;
    logic               any_hit;

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_dec
        assign gen_hit[g] = (addr == AW'(4 * g));
    end

    assign pd_hit  = (addr == AW'(PD_OFS));
    assign any_hit = (|gen_hit) || pd_hit;

    always_comb begin
        st_d     = st_q;
        st_d.err = wr_en && any_hit && locked;
        if (wr_en && !locked) begin
            for (int i = 0; i < NUM_GEN; i++) begin
                if (gen_hit[i]) st_d.gen[i] = wdata;
            end
            if (pd_hit && wdata[0]) st_d.pd = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gen_words  = st_q.gen;
    assign pd_bit     = st_q.pd;
    assign drop_pulse = st_q.err;

    initial begin
        assert (GEN_SPAN <= int'(PD_OFS)) else $error("general words overlap power-down offset");
    end

    AST_PD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        pd_bit |=> pd_bit); // R9
    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && wr_en) |=> ($stable(gen_words) && $stable(pd_bit))); // R6
endmodule

// File: rtl/cfg_keylock.sv
module cfg_keylock
    import cfg_keylock_pkg::*;
#(
    parameter int NUM_GEN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              pwr_sw_en,
    output logic              wr_err
);
    logic                            locked;
    logic                            wr_lock;
    logic [NUM_GEN-1:0][DATA_W-1:0]  gen_words;
    logic                            pd_bit;

    assign wr_lock = wr_en && (addr == LOCK_OFS);

    keylock_state #(.KW(KEY_W), .KEY(OPEN_KEY)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lock (wr_lock),
        .key_in  (wdata[KEY_W-1:0]),
        .locked  (locked)
    );

    guarded_bank #(.NUM_GEN(NUM_GEN), .AW(ADDR_W), .DW(DATA_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .locked     (locked),
        .gen_words  (gen_words),
        .pd_bit     (pd_bit),
        .drop_pulse (wr_err)
    );

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_GEN; i++) begin
            if (addr == ADDR_W'(4 * i)) rdata = gen_words[i];
        end
        if (addr == PD_OFS)   rdata = {{(DATA_W-1){1'b0}}, pd_bit};
        if (addr == LOCK_OFS) rdata = {{(DATA_W-1){1'b0}}, locked};
    end

    assign pwr_sw_en = pd_bit;

    AST_DROP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && wr_en && addr == PD_OFS) |=> wr_err); // R7
    AST_LOCK_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lock |=> !wr_err); // R10
endmodule

// File: tb/cfg_keylock_test.sv
`timescale 1ns/1ps
module cfg_keylock_test;
    localparam int NG = 2;
    localparam logic [15:0] KEY = 16'hAEE8;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [7:0]  addr = 0;
    logic [31:0] wdata = 0;
    logic [31:0] rdata;
    logic        pwr_sw_en;
    logic        wr_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic        m_lock;
    logic [31:0] m_gen [NG];
    logic        m_pd;

    always #2.5 clk = ~clk;

    cfg_keylock #(.NUM_GEN(NG)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pwr_sw_en(pwr_sw_en), .wr_err(wr_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_rd(input logic [7:0] a);
        for (int i = 0; i < NG; i++) if (a == 8'(4 * i)) return m_gen[i];
        if (a == 8'h34) return {31'b0, m_pd};
        if (a == 8'h38) return {31'b0, m_lock};
        return 32'h0; // R11
    endfunction

    task automatic rd(input string tag, input logic [7:0] a);
        @(negedge clk);
        addr = a;
        #1;
        chk(tag, rdata, model_rd(a));
    endtask

    task automatic rd_all(input string tag);
        for (int i = 0; i < NG; i++) rd(tag, 8'(4 * i));
        rd(tag, 8'h34);
        rd(tag, 8'h38);
        chk(tag, {31'b0, pwr_sw_en}, {31'b0, m_pd});
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic exp_err;
        logic hit;
        exp_err = 0;
        hit = 0;
        for (int i = 0; i < NG; i++) if (a == 8'(4 * i)) hit = 1;
        if (a == 8'h34) hit = 1;
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0;
        if (a == 8'h38) begin
            m_lock = (d[15:0] != KEY); // R2 R3 R10
        end else if (hit && m_lock) begin
            exp_err = 1; // R6
        end else if (hit) begin
            for (int i = 0; i < NG; i++) if (a == 8'(4 * i)) m_gen[i] = d; // R5
            if (a == 8'h34 && d[0]) m_pd = 1; // R8 R9
        end
        chk("R7 wr_err", {31'b0, wr_err}, {31'b0, exp_err});
        @(negedge clk);
        chk("R7 single pulse", {31'b0, wr_err}, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_lock = 0; m_pd = 0;
        for (int i = 0; i < NG; i++) m_gen[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd_all("R1 reset");
        chk("R1 err", {31'b0, wr_err}, 32'h0);

        // R5 open writes
        wr(8'h00, 32'hDEADBEEF);
        wr(8'h04, 32'h12345678);
        rd_all("R5 readback");

        // R2 R3 R4 R6 R10: strided key sweep
        for (int k = 0; k < 65536; k += 97) begin
            wr(8'h38, {16'(k * 3), 16'(k)});
            rd("R4 lock status", 8'h38);
            wr(8'h00, 32'(k) ^ 32'hA5A5_0F0F);
            rd("R6 guarded word", 8'h00);
            wr(8'h38, {16'(~k), KEY});
            rd("R2 reopen", 8'h38);
        end
        // single-bit neighbours of the key
        for (int b = 0; b < 16; b++) begin
            wr(8'h38, {16'hFFFF, KEY ^ 16'(1 << b)});
            rd("R3 near key", 8'h38);
            wr(8'h04, 32'(b));
            rd("R6 near key", 8'h04);
        end
        wr(8'h38, {16'h0000, KEY});
        rd("R10 unlock from closed", 8'h38);

        // R11 address sweep, open then closed
        for (int a = 0; a < 256; a++) begin
            if (a == 8'h38 || a == 8'h34) continue;
            wr(8'(a), 32'hC3C3_0000 | 32'(a) | 32'h2);
            rd_all("R11 open sweep");
        end
        wr(8'h38, 32'h0);
        for (int a = 0; a < 256; a++) begin
            if (a == 8'h38) continue;
            wr(8'(a), 32'h5A5A_FFFF);
            rd_all("R11 closed sweep");
        end

        // R8 R9 power-down
        wr(8'h38, {16'h0, KEY});
        wr(8'h34, 32'hFFFF_FFFE);
        rd_all("R8 bit0 only");
        wr(8'h34, 32'hFFFF_FFFF);
        rd_all("R8 set");
        chk("R8 pin", {31'b0, pwr_sw_en}, 32'h1);
        wr(8'h34, 32'h0);
        rd_all("R9 sticky open");
        wr(8'h38, 32'h1);
        wr(8'h34, 32'h0);
        rd_all("R9 sticky closed");

        // R9 only reset clears
        @(negedge clk);
        rst_n = 0;
        m_lock = 0; m_pd = 0;
        for (int i = 0; i < NG; i++) m_gen[i] = 0;
        @(negedge clk);
        rst_n = 1;
        rd_all("R9 reset clears");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule